// File: doc/BRIEF.md
# Repeated-Preamble Frame Timing and Coarse Frequency Offset Estimator

This block sits at the front of a single-carrier receiver. It takes one complex baseband sample per clock, qualified by a valid strobe. The start of each frame carries a preamble built from back-to-back copies of one known sequence. The block multiplies every sample by the conjugate of the sample one repetition earlier and keeps a running sum of these products over a sliding window. When the magnitude of that sum is large enough relative to the window energy, the block tracks its maximum. It confirms the peak once the magnitude has failed to grow for a programmable number of samples, and then issues a single sync pulse.

The complex correlation value held at the peak is passed to an iterative CORDIC vectoring unit. Its angle is the phase advance of the carrier over one repetition, which is the coarse frequency offset expressed as phase per lag. That angle is output together with a flag. The flag is high when the angle magnitude is above a programmable limit, and later stages use it to choose how they estimate IQ mismatch. After a sync pulse the detector stays idle until it is re-armed.

Top module: `presync_cfo_est`

## Requirements
- R1: While rst_ni is low, and after reset until the first estimate, sync_o, est_valid_o and iq_path_o are 0 and cfo_o is 0.
- R2: The correlation is C = sum over the last WIN (128) accepted samples of x[n]·conj(x[n-LAG]), where x = smp_re_i + j·smp_im_i. LAG defaults to 16, the repetition length.
- R3: Peak tracking starts only when (|Re C| + |Im C|)·64 > det_thr_i · E, where E is the sum of |x[n-LAG]|² over the same window. With det_thr_i = 127 a clean preamble gives no sync pulse.
- R4: With a preamble whose correlation magnitude peaks at sample p, sync_o is high for exactly one cycle. The pulse starts one clock edge after the edge that accepts sample p+H, where H = max(hold_i, 1).
- R5: After a sync pulse, no further sync pulse occurs until rearm_i has been high for at least one cycle. A frame sent before re-arming leaves sync_o, est_valid_o and cfo_o unchanged.
- R6: cfo_o is the angle of C at the peak as a signed 16-bit value, with 32768 standing for π. It covers the whole circle, including the left half-plane, and is accurate to within 24 LSB.
- R7: est_valid_o pulses for one cycle exactly ITER+1 (15) cycles after sync_o rises. cfo_o and iq_path_o change only together with that pulse and hold their values between pulses.
- R8: iq_path_o is 1 when |cfo_o| > cfo_thr_i, with cfo_thr_i sampled one cycle after sync_o. Otherwise it is 0.
- R9: Cycles with valid_i low change no internal state. Spreading a frame over alternate cycles gives the same sync position in accepted samples and the same cfo_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| smp_re_i | input | 12 | In-phase sample, signed |
| smp_im_i | input | 12 | Quadrature sample, signed |
| det_thr_i | input | 8 | Detection ratio in 1/64 units |
| hold_i | input | 6 | Samples without growth that confirm a peak |
| cfo_thr_i | input | 15 | Offset magnitude limit for iq_path_o |
| rearm_i | input | 1 | Re-enables detection after a sync |
| sync_o | output | 1 | One-cycle frame timing pulse |
| est_valid_o | output | 1 | One-cycle pulse when cfo_o updates |
| cfo_o | output | 16 | Phase per lag, signed, 32768 = π |
| iq_path_o | output | 1 | Offset above limit |

## Verification
The assertions assume that rearm_i is used only to restart detection and that the programmable inputs do not change while a frame is being tracked or while the CORDIC is iterating. The bench changes det_thr_i, hold_i and cfo_thr_i only between frames. Each frame is followed by at least WIN+LAG zero samples before re-arming, so no residue of one preamble can trigger the next detection. Preambles are exactly LAG+WIN samples long and have constant amplitude, so the correlation magnitude rises strictly to a single peak at the last preamble sample. This makes the peak sample known in advance.

// File: rtl/presync_pkg.sv
package presync_pkg;

  localparam int ANG_W = 16;

  typedef enum logic [1:0] {PK_ARMED, PK_TRACK, PK_DONE} pk_state_e;

  // atan(2^-k) scaled so that 2^(ANG_W-1) is pi
  function automatic int atan_lsb(input int k);
    case (k)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/presync_corr.sv
module presync_corr #(
  parameter int DW    = 12,
  parameter int LAG   = 16,
  parameter int WIN   = 128,
  parameter int ACC_W = 2*DW + 1 + $clog2(WIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [DW-1:0]    re_i,
  input  logic signed [DW-1:0]    im_i,
  output logic signed [ACC_W-1:0] acc_re_o,
  output logic signed [ACC_W-1:0] acc_im_o,
  output logic [ACC_W-1:0]        eng_o,
  output logic                    upd_o
);
  localparam int PW = 2*DW + 1;

  logic signed [DW-1:0] dl_re [LAG];
  logic signed [DW-1:0] dl_im [LAG];
  logic signed [PW-1:0] pl_re [WIN];
  logic signed [PW-1:0] pl_im [WIN];
  logic [PW-1:0]        pl_e  [WIN];

  logic signed [DW-1:0] old_re, old_im;
  logic signed [PW-1:0] p_re, p_im, p_e;

  assign old_re = dl_re[LAG-1];
  assign old_im = dl_im[LAG-1];

  // x[n] * conj(x[n-LAG])
  always_comb begin
    p_re = re_i * old_re + im_i * old_im;
    p_im = im_i * old_re - re_i * old_im;
    p_e  = old_re * old_re + old_im * old_im;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAG; k++) begin
        dl_re[k] <= '0;
        dl_im[k] <= '0;
      end
    end else if (valid_i) begin
      dl_re[0] <= re_i;
      dl_im[0] <= im_i;
      for (int k = 1; k < LAG; k++) begin
        dl_re[k] <= dl_re[k-1];
        dl_im[k] <= dl_im[k-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < WIN; k++) begin
        pl_re[k] <= '0;
        pl_im[k] <= '0;
        pl_e[k]  <= '0;
      end
    end else if (valid_i) begin
      pl_re[0] <= p_re;
      pl_im[0] <= p_im;
      pl_e[0]  <= $unsigned(p_e);
      for (int k = 1; k < WIN; k++) begin
        pl_re[k] <= pl_re[k-1];
        pl_im[k] <= pl_im[k-1];
        pl_e[k]  <= pl_e[k-1];
      end
    end
  end

  // recursive window sums: add newest, drop the one leaving
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
      eng_o    <= '0;
      upd_o    <= 1'b0;
    end else begin
      upd_o <= valid_i;
      if (valid_i) begin
        acc_re_o <= acc_re_o + ACC_W'(p_re) - ACC_W'(pl_re[WIN-1]);
        acc_im_o <= acc_im_o + ACC_W'(p_im) - ACC_W'(pl_im[WIN-1]);
        eng_o    <= eng_o + ACC_W'($unsigned(p_e)) - ACC_W'(pl_e[WIN-1]);
      end
    end
  end

endmodule

// File: rtl/presync_peak.sv
module presync_peak
  import presync_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int THR_W  = 8,
  parameter int HOLD_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] acc_re_i,
  input  logic signed [ACC_W-1:0] acc_im_i,
  input  logic [ACC_W-1:0]        eng_i,
  input  logic [THR_W-1:0]        det_thr_i,
  input  logic [HOLD_W-1:0]       hold_i,
  input  logic                    rearm_i,
  output logic                    sync_o,
  output logic signed [ACC_W-1:0] pk_re_o,
  output logic signed [ACC_W-1:0] pk_im_o
);
  localparam int MAG_W = ACC_W + 2;
  localparam int CMP_W = MAG_W + THR_W + 6;

  pk_state_e          st;
  logic [MAG_W-1:0]   mag, pk_max;
  logic [HOLD_W-1:0]  cnt;
  logic [HOLD_W:0]    cnt_nx;
  logic signed [ACC_W:0] sre, sim;
  logic [ACC_W:0]     a_re, a_im;
  logic [CMP_W-1:0]   lhs, rhs;
  logic               over;

  always_comb begin
    sre    = {acc_re_i[ACC_W-1], acc_re_i};
    sim    = {acc_im_i[ACC_W-1], acc_im_i};
    a_re   = $unsigned(sre[ACC_W] ? -sre : sre);
    a_im   = $unsigned(sim[ACC_W] ? -sim : sim);
    mag    = MAG_W'(a_re) + MAG_W'(a_im);
    lhs    = CMP_W'({mag, 6'b0});
    rhs    = CMP_W'(det_thr_i) * CMP_W'(eng_i);
    over   = lhs > rhs;
    cnt_nx = {1'b0, cnt} + {{HOLD_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= PK_ARMED;
      pk_max  <= '0;
      pk_re_o <= '0;
      pk_im_o <= '0;
      cnt     <= '0;
      sync_o  <= 1'b0;
    end else begin
      sync_o <= 1'b0;
      case (st)
        PK_ARMED: if (upd_i && over) begin
          st      <= PK_TRACK;
          pk_max  <= mag;
          pk_re_o <= acc_re_i;
          pk_im_o <= acc_im_i;
          cnt     <= '0;
        end
        PK_TRACK: if (upd_i) begin
          if (mag > pk_max) begin
            pk_max  <= mag;
            pk_re_o <= acc_re_i;
            pk_im_o <= acc_im_i;
            cnt     <= '0;
          end else if (cnt_nx >= {1'b0, hold_i}) begin
            sync_o <= 1'b1;
            st     <= PK_DONE;
          end else begin
            cnt <= cnt_nx[HOLD_W-1:0];
          end
        end
        PK_DONE: if (rearm_i) st <= PK_ARMED;
        default: st <= PK_ARMED;
      endcase
    end
  end

endmodule

// File: rtl/presync_cordic.sv
module presync_cordic
  import presync_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int ITER = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  input  logic [ANG_W-2:0]       thr_i,
  output logic                   valid_o,
  output logic signed [ANG_W-1:0] ang_o,
  output logic                   flag_o
);
  localparam int CW   = IN_W + 2;
  localparam int IT_W = $clog2(ITER) + 1;

  logic signed [CW-1:0]    x, y, xn, yn, xe, ye;
  logic signed [ANG_W-1:0] z, zn;
  logic [IT_W-1:0]         it;
  logic                    busy;
  logic [ANG_W-2:0]        thr_q;
  logic signed [ANG_W:0]   zw;
  logic [ANG_W:0]          zabs;

  assign xe = CW'(x_i);
  assign ye = CW'(y_i);

  always_comb begin
    if (!y[CW-1]) begin
      xn = x + (y >>> it);
      yn = y - (x >>> it);
      zn = z + ANG_W'(atan_lsb(int'(it)));
    end else begin
      xn = x - (y >>> it);
      yn = y + (x >>> it);
      zn = z - ANG_W'(atan_lsb(int'(it)));
    end
    zw   = {zn[ANG_W-1], zn};
    zabs = $unsigned(zw[ANG_W] ? -zw : zw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x       <= '0;
      y       <= '0;
      z       <= '0;
      it      <= '0;
      busy    <= 1'b0;
      thr_q   <= '0;
      valid_o <= 1'b0;
      ang_o   <= '0;
      flag_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        // left half-plane: rotate by pi, start angle at -pi (wraps)
        if (xe[CW-1]) begin
          x <= -xe;
          y <= -ye;
          z <= {1'b1, {(ANG_W-1){1'b0}}};
        end else begin
          x <= xe;
          y <= ye;
          z <= '0;
        end
        it    <= '0;
        busy  <= 1'b1;
        thr_q <= thr_i;
      end else if (busy) begin
        x  <= xn;
        y  <= yn;
        z  <= zn;
        it <= it + 1'b1;
        if (it == IT_W'(ITER-1)) begin
          busy    <= 1'b0;
          valid_o <= 1'b1;
          ang_o   <= zn;
          flag_o  <= zabs > {2'b00, thr_q};
        end
      end
    end
  end

endmodule

// File: rtl/presync_cfo_est.sv
module presync_cfo_est
  import presync_pkg::*;
#(
  parameter int DW     = 12,
  parameter int LAG    = 16,
  parameter int WIN    = 128,
  parameter int THR_W  = 8,
  parameter int HOLD_W = 6,
  parameter int ITER   = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [DW-1:0]    smp_re_i,
  input  logic signed [DW-1:0]    smp_im_i,
  input  logic [THR_W-1:0]        det_thr_i,
  input  logic [HOLD_W-1:0]       hold_i,
  input  logic [ANG_W-2:0]        cfo_thr_i,
  input  logic                    rearm_i,
  output logic                    sync_o,
  output logic                    est_valid_o,
  output logic signed [ANG_W-1:0] cfo_o,
  output logic                    iq_path_o
);
  localparam int ACC_W = 2*DW + 1 + $clog2(WIN);

  logic signed [ACC_W-1:0] acc_re, acc_im, pk_re, pk_im;
  logic [ACC_W-1:0]        eng;
  logic                    upd;

  presync_corr #(.DW(DW), .LAG(LAG), .WIN(WIN), .ACC_W(ACC_W)) u_corr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .re_i     (smp_re_i),
    .im_i     (smp_im_i),
    .acc_re_o (acc_re),
    .acc_im_o (acc_im),
    .eng_o    (eng),
    .upd_o    (upd)
  );

  presync_peak #(.ACC_W(ACC_W), .THR_W(THR_W), .HOLD_W(HOLD_W)) u_peak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .acc_re_i  (acc_re),
    .acc_im_i  (acc_im),
    .eng_i     (eng),
    .det_thr_i (det_thr_i),
    .hold_i    (hold_i),
    .rearm_i   (rearm_i),
    .sync_o    (sync_o),
    .pk_re_o   (pk_re),
    .pk_im_o   (pk_im)
  );

  presync_cordic #(.IN_W(ACC_W), .ITER(ITER)) u_cordic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sync_o),
    .x_i     (pk_re),
    .y_i     (pk_im),
    .thr_i   (cfo_thr_i),
    .valid_o (est_valid_o),
    .ang_o   (cfo_o),
    .flag_o  (iq_path_o)
  );

endmodule

// File: rtl/presync_chk.sv
module presync_chk
  import presync_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    rearm_i,
  input logic                    sync_o,
  input logic                    est_valid_o,
  input logic signed [ANG_W-1:0] cfo_o,
  input logic                    iq_path_o
);
  logic got_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       got_sync <= 1'b0;
    else if (sync_o)   got_sync <= 1'b1;
    else if (rearm_i)  got_sync <= 1'b0;
  end

  assert_sync_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  assert_sync_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    got_sync |-> !sync_o);

  assert_est_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_valid_o |=> !est_valid_o);

  assert_est_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !est_valid_o |-> ($stable(cfo_o) && $stable(iq_path_o)));

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !est_valid_o);

endmodule

bind presync_cfo_est presync_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rearm_i     (rearm_i),
  .sync_o      (sync_o),
  .est_valid_o (est_valid_o),
  .cfo_o       (cfo_o),
  .iq_path_o   (iq_path_o)
);

// File: tb/sim_presync_cfo_est.sv
module sim_presync_cfo_est;
  localparam int  LAG  = 16;
  localparam int  WIN  = 128;
  localparam int  ITER = 14;
  localparam int  PLEN = LAG + WIN;
  localparam int  TAIL = WIN + LAG + 40;
  localparam real AMP  = 1500.0;
  localparam real PI   = 3.14159265358979;
  localparam int  TOL  = 24;

  localparam int N_VEC = 6;
  localparam int V_MRAD [N_VEC] = '{300, -900, 2500, -2800, 50, 1500};
  localparam int V_THR  [N_VEC] = '{5000, 5000, 20000, 20000, 1, 16000};
  localparam int V_FLAG [N_VEC] = '{0, 1, 1, 1, 1, 0};

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [11:0] smp_re_i = '0, smp_im_i = '0;
  logic [7:0]         det_thr_i = 8'd48;
  logic [5:0]         hold_i = 6'd4;
  logic [14:0]        cfo_thr_i = '0;
  logic               rearm_i = 1'b0;
  logic               sync_o, est_valid_o, iq_path_o;
  logic signed [15:0] cfo_o;

  int n_chk = 0, n_fail = 0;
  int n_acc, cyc, sync_n, sync_at, sync_cyc, est_n, est_cyc;
  logic signed [15:0] est_ang;
  logic               est_flag;

  always #10 clk_i = ~clk_i;

  presync_cfo_est u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int re, input int im);
    int prev;
    valid_i  = v;
    smp_re_i = 12'(re);
    smp_im_i = 12'(im);
    prev = n_acc;
    @(posedge clk_i);
    if (v) n_acc++;
    @(negedge clk_i);
    cyc++;
    if (sync_o) begin
      sync_n++;
      sync_at  = prev;
      sync_cyc = cyc;
    end
    if (est_valid_o) begin
      est_n++;
      est_cyc  = cyc;
      est_ang  = cfo_o;
      est_flag = iq_path_o;
    end
  endtask

  task automatic run_frame(input int mrad, input bit gap, input bit rearm);
    real w;
    n_acc = 0; cyc = 0; sync_n = 0; est_n = 0; sync_at = -1; sync_cyc = -1; est_cyc = -1;
    w = (real'(mrad) / 1000.0) / real'(LAG);
    for (int k = 0; k < PLEN; k++) begin
      if (gap) step(1'b0, 0, 0);
      step(1'b1, int'(AMP * $cos(w * k + 0.4)), int'(AMP * $sin(w * k + 0.4)));
    end
    for (int k = 0; k < TAIL; k++) begin
      if (gap) step(1'b0, 0, 0);
      step(1'b1, 0, 0);
    end
    valid_i = 1'b0;
    if (rearm) begin
      rearm_i = 1'b1;
      step(1'b0, 0, 0);
      rearm_i = 1'b0;
    end
  endtask

  task automatic check_est(input int mrad, input int flag, input int hold, input string tag);
    int exp_lsb, d;
    logic signed [15:0] dd;
    exp_lsb = int'((real'(mrad) / 1000.0) * 32768.0 / PI);
    dd = est_ang - 16'(exp_lsb);
    d  = (dd < 0) ? -int'(dd) : int'(dd);
    chk(sync_n == 1, {tag, " R4 sync count"}, sync_n, 1);
    chk(sync_at == PLEN + hold, {tag, " R4 sync position"}, sync_at, PLEN + hold);
    chk(est_n == 1 && est_cyc - sync_cyc == ITER + 1, {tag, " R7 latency"}, est_cyc - sync_cyc, ITER + 1);
    chk(d <= TOL, {tag, " R6 R2 angle"}, int'(est_ang), exp_lsb);
    chk(int'(est_flag) == flag, {tag, " R8 flag"}, int'(est_flag), flag);
    chk(cfo_o == est_ang, {tag, " R7 held"}, int'(cfo_o), int'(est_ang));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic signed [15:0] keep;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(sync_o == 1'b0, "R1 sync_o", int'(sync_o), 0);
    chk(est_valid_o == 1'b0, "R1 est_valid_o", int'(est_valid_o), 0);
    chk(cfo_o == 16'sd0, "R1 cfo_o", int'(cfo_o), 0);
    chk(iq_path_o == 1'b0, "R1 iq_path_o", int'(iq_path_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < N_VEC; v++) begin
      cfo_thr_i = 15'(V_THR[v]);
      run_frame(V_MRAD[v], 1'b0, 1'b1);
      check_est(V_MRAD[v], V_FLAG[v], 4, $sformatf("vec%0d", v));
    end

    // R4 longer hold
    hold_i = 6'd9; cfo_thr_i = 15'd5000;
    run_frame(-600, 1'b0, 1'b1);
    check_est(-600, 1, 9, "hold9");
    hold_i = 6'd4;

    // R9 gaps in valid
    run_frame(900, 1'b1, 1'b1);
    check_est(900, 1, 4, "gap R9");

    // R3 threshold above any achievable ratio
    det_thr_i = 8'd127;
    run_frame(300, 1'b0, 1'b0);
    chk(sync_n == 0, "R3 no sync", sync_n, 0);
    chk(est_n == 0, "R3 no estimate", est_n, 0);
    det_thr_i = 8'd48;

    // R5 no re-arm: second frame ignored
    run_frame(700, 1'b0, 1'b0);
    chk(sync_n == 1, "R5 first frame sync", sync_n, 1);
    keep = cfo_o;
    run_frame(-1200, 1'b0, 1'b0);
    chk(sync_n == 0, "R5 second frame sync", sync_n, 0);
    chk(est_n == 0, "R5 second frame estimate", est_n, 0);
    chk(cfo_o == keep, "R5 cfo_o unchanged", int'(cfo_o), int'(keep));
    rearm_i = 1'b1;
    step(1'b0, 0, 0);
    rearm_i = 1'b0;
    run_frame(-1200, 1'b0, 1'b1);
    check_est(-1200, 1, 4, "rearm R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule